// File: doc/BRIEF.md
# Backplane Bus Target Emulator

This block is the target side of a function-code / sub-address backplane bus, built for test benches and bring-up boards. Each transaction is a single-cycle strobe carrying a 4-bit function code, an 11-bit sub-address and a 16-bit write word. The block decodes the function and does one of the following:
- writes to or reads from a first-in first-out store of 16-bit words;
- returns the packed FIFO pointers;
- accesses a flat file of 2048 16-bit registers;
- refuses the transaction.

Every accepted transaction is answered one clock after its strobe with an acknowledge, a YSSIR response and usually a Q response. Read data is presented in the same cycle. Refused transactions produce no response at all.

The FIFO is a ring of 1024 slots addressed by wrapping pointers, so it holds at most 1023 words. It has no guard against writing while full. A read from an empty FIFO returns no Q and leaves the pointers alone.

Top module: `bpb_target`

## Requirements
- R1: Function codes 3, 7 and 9 are refused. In the cycle after such a strobe, ack_o, q_o and yssir_o are low and rdata_o is 0. FIFO pointers and register contents are unchanged.
- R2: For every other function code, ack_o and yssir_o are high for exactly the one cycle that follows the strobe. They are never high in a cycle that does not follow a strobe.
- R3: Function 8 appends wdata_i to the FIFO and function 0 removes the oldest word and returns it on rdata_o. Both ignore sa_i, and q_o is high for both unless R4 applies.
- R4: Function 0 on an empty FIFO (write pointer equal to read pointer) answers with ack_o and yssir_o high, q_o low and rdata_o 0. Both pointers are left unchanged.
- R5: Starting from empty, the FIFO accepts 1023 writes and returns all 1023 words in write order.
- R6: Writing is not guarded. A write into a FIFO that already holds 1023 words advances the write pointer onto the read pointer, so the FIFO then reads as empty.
- R7: Function 1 returns a word whose bits 15:8 are the low 8 bits of the write pointer and whose bits 7:0 are the low 8 bits of the read pointer. Pointers start at 0 and each advances by one per write or read, modulo 1024.
- R8: Any other function code with bit 3 set (10 to 15) writes wdata_i to register sa_i. Any other code with bit 3 clear (2, 4, 5, 6) returns register sa_i on rdata_o. Bits 2:0 of the code do not select the location.
- R9: While rst_ni is low, ack_o, q_o, yssir_o and rdata_o are 0 and both FIFO pointers are cleared.
- R10: rdata_o is 0 whenever ack_o is low, and also after FIFO writes and register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | One-cycle transaction strobe |
| fn_i | input | 4 | Function code |
| sa_i | input | 11 | Sub-address (register index) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the ack cycle |
| q_o | output | 1 | Q response |
| yssir_o | output | 1 | YSSIR response (function accepted) |
| ack_o | output | 1 | Acknowledge, one cycle after an accepted strobe |

## Verification
The bound checker enforces the response protocol on every cycle:
- refusals stay silent and leave the pointers still;
- accepted strobes are acknowledged one cycle later and nothing is acknowledged without a strobe;
- Q never appears without an acknowledge;
- read data is quiet outside acknowledged cycles;
- an empty FIFO read drops Q and holds the read pointer.

Data correctness only shows up in the bench's scenarios, because it depends on history:
- FIFO ordering;
- the full 1023-word fill and drain;
- the wrap that empties the FIFO on the 1024th write;
- the packed pointer word;
- register aliasing across function codes.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
  localparam int FN_W = 4;

  typedef enum logic [2:0] {
    OP_REJ,  // refused, or idle
    OP_FWR,  // FIFO append
    OP_FRD,  // FIFO remove
    OP_PTR,  // packed pointer readback
    OP_RWR,  // register write
    OP_RRD   // register read
  } op_e;

  function automatic op_e decode_fn(input logic [FN_W-1:0] fn);
    op_e op;
    case (fn)
      4'd3, 4'd7, 4'd9: op = OP_REJ;
      4'd8:             op = OP_FWR;
      4'd0:             op = OP_FRD;
      4'd1:             op = OP_PTR;
      default:          op = fn[3] ? OP_RWR : OP_RRD;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/bpb_decode.sv
module bpb_decode
  import bpb_pkg::*;
(
  input  logic            strobe_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            fifo_empty_i,
  output op_e             op_o,
  output logic            accept_o,
  output logic            push_o,
  output logic            pop_o,
  output logic            reg_we_o,
  output logic            reg_re_o
);
  always_comb begin
    op_o     = decode_fn(fn_i);
    accept_o = strobe_i && (op_o != OP_REJ);
    push_o   = strobe_i && (op_o == OP_FWR);
    // empty read leaves pointers alone
    pop_o    = strobe_i && (op_o == OP_FRD) && !fifo_empty_i;
    reg_we_o = strobe_i && (op_o == OP_RWR);
    reg_re_o = strobe_i && (op_o == OP_RRD);
  end
endmodule

// File: rtl/bpb_fifo.sv
module bpb_fifo #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic          empty_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= wdata_i;
  end

  // no full guard: a push onto a full ring lands on rptr and reads as empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop_i) begin
        rdata_o <= mem[rptr_q];
        rptr_q  <= rptr_q + 1'b1;
      end
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign empty_o = (wptr_q == rptr_q);
endmodule

// File: rtl/bpb_regfile.sv
module bpb_regfile #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/bpb_target.sv
module bpb_target
  import bpb_pkg::*;
#(
  parameter int DW      = 16,
  parameter int FIFO_AW = 10,
  parameter int REG_AW  = 11,
  parameter int PTR_VIS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [FN_W-1:0]    fn_i,
  input  logic [REG_AW-1:0]  sa_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               q_o,
  output logic               yssir_o,
  output logic               ack_o
);
  localparam int PTR_W = 2 * PTR_VIS;

  op_e               op;
  logic              accept, push, pop, reg_we, reg_re;
  logic              fifo_empty;
  logic [DW-1:0]     fifo_rdata, reg_rdata;
  logic [FIFO_AW-1:0] fifo_wptr, fifo_rptr;
  logic [PTR_W-1:0]  ptr_word;

  op_e               op_q;
  logic              ack_q, q_q, yssir_q;
  logic [DW-1:0]     ptr_q;

  bpb_decode u_dec (
    .strobe_i     (strobe_i),
    .fn_i         (fn_i),
    .fifo_empty_i (fifo_empty),
    .op_o         (op),
    .accept_o     (accept),
    .push_o       (push),
    .pop_o        (pop),
    .reg_we_o     (reg_we),
    .reg_re_o     (reg_re)
  );

  bpb_fifo #(.AW(FIFO_AW), .DW(DW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wdata_i),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .wptr_o  (fifo_wptr),
    .rptr_o  (fifo_rptr),
    .empty_o (fifo_empty)
  );

  bpb_regfile #(.AW(REG_AW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .re_i    (reg_re),
    .addr_i  (sa_i),
    .wdata_i (wdata_i),
    .rdata_o (reg_rdata)
  );

  assign ptr_word = {fifo_wptr[PTR_VIS-1:0], fifo_rptr[PTR_VIS-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_REJ;
      ack_q   <= 1'b0;
      yssir_q <= 1'b0;
      q_q     <= 1'b0;
      ptr_q   <= '0;
    end else begin
      op_q    <= strobe_i ? op : OP_REJ;
      ack_q   <= accept;
      yssir_q <= strobe_i && (op != OP_REJ);
      q_q     <= accept && !((op == OP_FRD) && fifo_empty);
      if (strobe_i && (op == OP_PTR)) ptr_q <= DW'(ptr_word);
    end
  end

  always_comb begin
    case (op_q)
      OP_FRD:  rdata_o = q_q ? fifo_rdata : '0;
      OP_PTR:  rdata_o = ptr_q;
      OP_RRD:  rdata_o = reg_rdata;
      default: rdata_o = '0;
    endcase
  end

  assign ack_o   = ack_q;
  assign yssir_o = yssir_q;
  assign q_o     = q_q;
endmodule

// File: rtl/bpb_target_chk.sv
module bpb_target_chk #(
  parameter int DW      = 16,
  parameter int FIFO_AW = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               strobe_i,
  input logic [3:0]         fn_i,
  input logic [DW-1:0]      rdata_o,
  input logic               q_o,
  input logic               yssir_o,
  input logic               ack_o,
  input logic [FIFO_AW-1:0] wptr,
  input logic [FIFO_AW-1:0] rptr
);
  logic refused;
  assign refused = (fn_i == 4'd3) || (fn_i == 4'd7) || (fn_i == 4'd9);

  // R1
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && refused |=> !ack_o && !q_o && !yssir_o);

  // R1
  reject_keeps_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && refused |=> $stable(wptr) && $stable(rptr));

  // R2
  accept_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !refused |=> ack_o && yssir_o);

  // R2
  no_stray_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !ack_o && !yssir_o);

  // R3
  q_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o |-> ack_o);

  // R4
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (fn_i == 4'd0) && (wptr == rptr) |=> !q_o && $stable(rptr));

  // R10
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == '0);
endmodule

bind bpb_target bpb_target_chk #(.DW(DW), .FIFO_AW(FIFO_AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .fn_i     (fn_i),
  .rdata_o  (rdata_o),
  .q_o      (q_o),
  .yssir_o  (yssir_o),
  .ack_o    (ack_o),
  .wptr     (fifo_wptr),
  .rptr     (fifo_rptr)
);

// File: tb/tb_bpb_target.sv
module tb_bpb_target;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [3:0]  fn_i = '0;
  logic [10:0] sa_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        q_o, yssir_o, ack_o;

  always #5 clk_i = ~clk_i;

  bpb_target dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .fn_i(fn_i),
    .sa_i(sa_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .q_o(q_o),
    .yssir_o(yssir_o), .ack_o(ack_o)
  );

  typedef struct {
    logic        ack;
    logic        q;
    logic        yssir;
    logic [15:0] rdata;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [15:0] m_fifo [1024];
  logic [15:0] m_reg [2048];
  int          mw = 0;
  int          mr = 0;
  logic        pending = 1'b0;

  // driver: call at a negedge; holds strobe for one cycle
  task automatic issue(input logic [3:0] fn, input logic [10:0] sa,
                       input logic [15:0] wd, input string req);
    exp_t e;
    e.ack = 1'b1; e.q = 1'b1; e.yssir = 1'b1; e.rdata = '0; e.req = req;
    if (fn == 4'd3 || fn == 4'd7 || fn == 4'd9) begin
      e.ack = 1'b0; e.q = 1'b0; e.yssir = 1'b0;
    end else if (fn == 4'd8) begin
      m_fifo[mw] = wd; mw = (mw + 1) % 1024;
    end else if (fn == 4'd0) begin
      if (mw == mr) e.q = 1'b0;
      else begin e.rdata = m_fifo[mr]; mr = (mr + 1) % 1024; end
    end else if (fn == 4'd1) begin
      e.rdata = {mw[7:0], mr[7:0]};
    end else if (fn[3]) begin
      m_reg[sa] = wd;
    end else begin
      e.rdata = m_reg[sa];
    end
    sb.push_back(e);
    fn_i = fn; sa_i = sa; wdata_i = wd; strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_out(input string req, input logic [18:0] act,
                           input logic [18:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s ack/q/yssir/rdata act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) pending <= strobe_i;

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && pending) begin
        if (sb.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 unexpected response act=%b exp=none", ack_o);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check_out(e.req, {ack_o, q_o, yssir_o, rdata_o},
                    {e.ack, e.q, e.yssir, e.rdata});
        end
      end else if (rst_ni && (ack_o || q_o || yssir_o || rdata_o != 0)) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 output without strobe act=%b%b%b_%h exp=0",
                 ack_o, q_o, yssir_o, rdata_o);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check_out("R9", {ack_o, q_o, yssir_o, rdata_o}, 19'h0);
    rst_ni = 1'b1;
    idle(2);

    issue(4'd1, 11'd5, 16'h0, "R7");          // R7 pointers start at 0
    issue(4'd0, 11'd0, 16'h0, "R4");          // R4 empty read
    issue(4'd1, 11'd0, 16'h0, "R4");

    // R8 register writes over all write codes, reads over all read codes
    issue(4'd10, 11'd0,    16'h1111, "R8");
    issue(4'd15, 11'd2047, 16'hBEEF, "R8");
    issue(4'd12, 11'd300,  16'h5A5A, "R8");
    issue(4'd2,  11'd2047, 16'h0,    "R8");
    issue(4'd6,  11'd0,    16'h0,    "R8");
    issue(4'd4,  11'd300,  16'h0,    "R8");
    issue(4'd11, 11'd300,  16'hC3C3, "R8");
    issue(4'd5,  11'd300,  16'h0,    "R8");
    issue(4'd13, 11'd7,    16'h0707, "R10");  // R10 write returns 0
    issue(4'd14, 11'd8,    16'h0808, "R8");
    issue(4'd6,  11'd8,    16'h0,    "R8");

    // R1 refusals: no response, no state change
    issue(4'd9, 11'd0, 16'hDEAD, "R1");
    issue(4'd3, 11'd0, 16'hDEAD, "R1");
    issue(4'd7, 11'd300, 16'hDEAD, "R1");
    issue(4'd2, 11'd0, 16'h0, "R1");
    issue(4'd1, 11'd0, 16'h0, "R1");

    // R3 FIFO order, sa ignored
    issue(4'd8, 11'd1,   16'hA001, "R3");
    issue(4'd8, 11'd999, 16'hA002, "R3");
    issue(4'd8, 11'd33,  16'hA003, "R3");
    idle(1);
    issue(4'd1, 11'd0, 16'h0, "R7");
    issue(4'd0, 11'd44,  16'h0, "R3");
    issue(4'd0, 11'd2000, 16'h0, "R3");
    issue(4'd1, 11'd0, 16'h0, "R7");
    issue(4'd0, 11'd0, 16'h0, "R3");
    issue(4'd0, 11'd0, 16'h0, "R4");
    issue(4'd1, 11'd0, 16'h0, "R4");

    // R5 fill to 1023 then drain
    for (int i = 0; i < 1023; i++) issue(4'd8, 11'(i), 16'(16'h4000 + i * 7), "R5");
    issue(4'd1, 11'd0, 16'h0, "R5");
    for (int i = 0; i < 1023; i++) issue(4'd0, 11'd0, 16'h0, "R5");
    issue(4'd0, 11'd0, 16'h0, "R5");
    issue(4'd1, 11'd0, 16'h0, "R7");

    // R6 1024 writes wrap onto rptr, FIFO reads as empty
    for (int i = 0; i < 1024; i++) issue(4'd8, 11'd0, 16'(16'h9000 + i), "R6");
    issue(4'd1, 11'd0, 16'h0, "R6");
    issue(4'd0, 11'd0, 16'h0, "R6");
    issue(4'd8, 11'd0, 16'h1234, "R6");
    issue(4'd0, 11'd0, 16'h0, "R6");

    idle(4);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 missing responses act=%0d exp=0", sb.size());
    end
    finish_run();
  end
endmodule